// File: doc/BRIEF.md
# Bus Clock Pin Divider

This block puts a slowed copy of the bus clock onto one general-purpose pin that is otherwise owned by an ordinary I/O port. When clock output is switched on, the block takes the pin from the port. It drives a square wave whose period is a selectable multiple of the bus clock period, and it forces the pin to be an output. When clock output is switched off, the port's own data and direction signals pass through to the pin unchanged.

The divide code is read every bus cycle. A new code, or a fresh enable, restarts the divider so the first output phase is always a full low phase. The clock level comes straight from a flip-flop clocked by the bus clock. Every pin signal is a plain level, so no valid/ready handshake applies and there is no back-pressure. Slew-rate and drive-strength bits for the pad are wired to the pad elsewhere and do not pass through this logic.

Top module: `clkout_pin_driver`

## Requirements
- R1: With `clk_out_en`=1 and a nonzero code N on `div_sel`, `pin_out` is a square wave with a period of 2×N bus cycles and a 50% duty cycle: N cycles low, then N cycles high.
- R2: Every nonzero code from 1 to 7 gives its own period. Code 1 gives the bus frequency divided by 2, and code 7 gives it divided by 14.
- R3: While `clk_out_en`=1, `pin_oe` is 1 whatever value `port_dir` has.
- R4: While `clk_out_en`=1 and `div_sel`=0, `pin_out` stays 0 in every cycle.
- R5: While `clk_out_en`=0, `pin_out` equals `port_dout` and `pin_oe` equals `port_dir`.
- R6: If `div_sel` changes while enabled, the rising edge where the new code is first sampled restarts the divider. `pin_out` is then low for N cycles, counted from that edge, and goes high at the N-th edge after it.
- R7: Raising `clk_out_en` restarts the divider in the same way as R6. This applies after reset and after any disabled interval.
- R8: While `rst_n`=0, the divider state is cleared, so an enabled pin reads `pin_out`=0 with `pin_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_out_en | input | 1 | 1 hands the pin to the clock output |
| div_sel | input | 3 | Divide code; 0 holds the pin low, N divides by 2×N |
| port_dout | input | 1 | Port data value for the pin |
| port_dir | input | 1 | Port direction, 1 = output |
| pin_out | output | 1 | Value driven to the pad |
| pin_oe | output | 1 | Pad output enable |

## Verification
Two functions can act on the same cycle. A divide-code change (restart) can land on the very edge where the divider would otherwise toggle at the end of a phase, and an enable edge can land in the middle of a high phase. The bench provokes both by changing the code or dropping the enable partway through a running wave. It judges every cycle against a reference that counts cycles since the last restart, and it requires the restart to win: the output must be low, with no toggle, on the edge after the collision.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  parameter int unsigned SEL_W_DEFAULT = 3;

  typedef enum logic {
    SRC_PORT  = 1'b0,
    SRC_CLOCK = 1'b1
  } pin_src_e;
endpackage

// File: rtl/clkout_restart_detect.sv
module clkout_restart_detect #(
  parameter int unsigned SEL_W = clkout_pkg::SEL_W_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [SEL_W-1:0] sel_q,
  output logic             restart
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      en_q  <= en;
      sel_q <= sel;
    end
  end

  // Restart on disable, on the first enabled edge, and on any code change.
  assign restart = !en || !en_q || (sel != sel_q);

  // R7: an enabled edge that follows a disabled one must restart
  p_enable_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !$past(en)) |-> restart);
endmodule

// File: rtl/clkout_divider.sv
module clkout_divider #(
  parameter int unsigned SEL_W = clkout_pkg::SEL_W_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel_q,
  output logic             phase
);
  localparam logic [SEL_W-1:0] ONE = SEL_W'(1);

  logic [SEL_W-1:0] cnt;
  logic             phase_end;

  assign phase_end = (cnt == sel_q - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (restart || (sel_q == '0)) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (phase_end) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + ONE;
    end
  end

  // R6: a restart always leaves the wave at the start of a low phase
  p_restart_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!phase && cnt == '0));

  // R1: the last count of a phase flips the level
  p_toggle_at_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && sel_q != '0 && cnt == sel_q - ONE) |=> (phase != $past(phase)));

  // R2: the counter never passes the selected half period
  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != '0) |-> (cnt < sel_q));
endmodule

// File: rtl/clkout_pin_mux.sv
module clkout_pin_mux (
  input  logic en,
  input  logic phase,
  input  logic port_dout,
  input  logic port_dir,
  output logic pin_out,
  output logic pin_oe
);
  import clkout_pkg::*;

  pin_src_e src;

  assign src = en ? SRC_CLOCK : SRC_PORT;

  always_comb begin
    unique case (src)
      SRC_CLOCK: begin
        pin_out = phase;
        pin_oe  = 1'b1;
      end
      default: begin
        pin_out = port_dout;
        pin_oe  = port_dir;
      end
    endcase
  end
endmodule

// File: rtl/clkout_pin_driver.sv
module clkout_pin_driver #(
  parameter int unsigned SEL_W = clkout_pkg::SEL_W_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_out_en,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             port_dout,
  input  logic             port_dir,
  output logic             pin_out,
  output logic             pin_oe
);
  logic [SEL_W-1:0] sel_q;
  logic             restart;
  logic             phase;

  clkout_restart_detect #(.SEL_W(SEL_W)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (clk_out_en),
    .sel     (div_sel),
    .sel_q   (sel_q),
    .restart (restart)
  );

  clkout_divider #(.SEL_W(SEL_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .sel_q   (sel_q),
    .phase   (phase)
  );

  clkout_pin_mux u_mux (
    .en        (clk_out_en),
    .phase     (phase),
    .port_dout (port_dout),
    .port_dir  (port_dir),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  // R4: a zero code held across edges keeps the pin low
  p_zero_code_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_out_en && $past(clk_out_en) && div_sel == '0 && $past(div_sel) == '0) |-> !pin_out);

  // R3: clock ownership forces the pad to drive
  p_oe_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out_en |-> pin_oe);

  // R5: with clock output off the port owns the pin
  p_port_passthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_out_en |-> (pin_out == port_dout && pin_oe == port_dir));
endmodule

// File: tb/sim_clkout_pin_driver.sv
module sim_clkout_pin_driver;
  typedef struct {
    logic  out;
    logic  oe;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       dout = 1'b0;
  logic       dir = 1'b0;
  logic       pin_out, pin_oe;

  int   n_vec = 0;
  int   n_bad = 0;
  exp_t sb[$];

  bit         m_prev_en = 1'b0;
  logic [2:0] m_prev_sel = 3'd0;
  int         m_age = 0;

  always #5 clk = ~clk;

  clkout_pin_driver u0 (
    .clk(clk), .rst_n(rst_n), .clk_out_en(en), .div_sel(sel),
    .port_dout(dout), .port_dir(dir), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input logic a_out, input logic a_oe, input exp_t e);
    n_vec++;
    if (a_out !== e.out || a_oe !== e.oe) begin
      n_bad++;
      $display("FAIL %s: out=%b oe=%b expected out=%b oe=%b", e.tag, a_out, a_oe, e.out, e.oe);
    end
  endtask

  // Driver: applies one setting for n cycles and pushes the expected pin state
  task automatic apply(input logic e, input logic [2:0] s, input logic d,
                       input logic r, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t x;
      @(negedge clk); #1;
      en = e; sel = s; dout = d; dir = r;
      @(posedge clk); #1;
      if (!e || !m_prev_en || s != m_prev_sel) m_age = 0;
      else m_age++;
      m_prev_en = e; m_prev_sel = s;
      x.tag = tag;
      if (e) begin
        x.oe  = 1'b1;
        x.out = (s == 3'd0) ? 1'b0 : logic'((m_age / int'(s)) % 2);
      end else begin
        x.oe  = r;
        x.out = d;
      end
      sb.push_back(x);
    end
  endtask

  // Monitor: compares at the falling edge after each prediction
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        check(pin_out, pin_oe, x);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: out=%b oe=%b expected run to end", pin_out, pin_oe);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    exp_t r8;
    en = 1'b1; sel = 3'd3; dir = 1'b0; dout = 1'b1;
    repeat (3) @(negedge clk);
    r8.out = 1'b0; r8.oe = 1'b1; r8.tag = "R8 reset";
    check(pin_out, pin_oe, r8);
    en = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    // R5 port passthrough across patterns
    apply(0, 3'd4, 1, 1, 2, "R5");
    apply(0, 3'd4, 0, 1, 2, "R5");
    apply(0, 3'd2, 1, 0, 2, "R5");
    apply(0, 3'd0, 0, 0, 2, "R5");
    // R7 enable after disable, then R1 steady wave
    apply(1, 3'd3, 0, 0, 6, "R7");
    apply(1, 3'd3, 0, 0, 18, "R1");
    // R2 sweep of every nonzero code
    for (int c = 1; c < 8; c++) apply(1, 3'(c), 1, 0, 4 * c, "R2");
    // R6 code change in mid phase and on a phase boundary
    apply(1, 3'd5, 0, 0, 7, "R6");
    apply(1, 3'd2, 0, 0, 10, "R6");
    apply(1, 3'd4, 0, 0, 4, "R6");
    apply(1, 3'd1, 0, 0, 6, "R6");
    // R4 zero code with port data high, R3 forced drive with dir low
    apply(1, 3'd0, 1, 0, 10, "R4");
    apply(1, 3'd6, 1, 0, 9, "R3");
    // R7 drop enable in high phase, then re-enable
    apply(0, 3'd6, 1, 1, 3, "R5");
    apply(1, 3'd6, 0, 0, 14, "R7");
    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule